// File: doc/BRIEF.md
# Execute Unit with Flags and Branch Decision

This block is the compute step of a small single-cycle processor. Each cycle it receives a decoded opcode, a function code and three words: two values read from registers and the constant carried by the instruction. From the opcode alone it picks the two operands of its arithmetic unit. These can be register values, the constant, a fixed stack step of four added or subtracted, or zero. It then produces one result word. The result serves as the arithmetic value, the effective address or the adjusted stack pointer, depending on the instruction.

A three-bit flag register (zero, sign, signed overflow) is the only state. It is written at the clock edge, and only by arithmetic/logic instructions. A conditional jump decides its outcome from the function code and the stored flags, so the decision always reflects the last arithmetic instruction before the jump. The result and the branch decision are combinational. Memory access, the register file and the choice of the next program counter are done elsewhere.

Top module: `exec_unit`

## Requirements
- R1: For opcode 6, the result is val_b OP val_a. Function 0 adds, 1 subtracts (val_b minus val_a), 2 is bitwise AND and 3 is bitwise XOR. Function codes 4 to 15 behave as addition.
- R2: Opcode 2 (register copy) gives val_a. Opcode 3 (constant load) gives val_c.
- R3: Opcodes 4 (store) and 5 (load) give val_b + val_c as the address.
- R4: Opcodes 10 (push) and 8 (call) give val_b - 4. Opcodes 11 (pop) and 9 (return) give val_b + 4.
- R5: Opcodes 0, 1 and 7, and the unused opcodes 12 to 15, give a result of zero.
- R6: The flags {zero, sign, overflow} load at the rising clock edge only while the opcode is 6. Every other opcode leaves them unchanged.
- R7: Add overflows when both operands share a sign and the result's sign differs. Subtract overflows when the signs of val_b and val_a differ and the result's sign differs from val_b. AND and XOR clear overflow.
- R8: Reset sets the flags to zero=1, sign=0, overflow=0. As a result, jump-if-equal is taken and jump-if-not-equal is not.
- R9: For opcode 7, each function code has its own condition, where less means sign XOR overflow. Code 0 is always taken. Code 1 is taken when less or zero. Code 2 is taken when less. Code 3 is taken when zero. Code 4 is taken when not zero. Code 5 is taken when not less. Code 6 is taken when neither less nor zero.
- R10: branch_taken is 0 for every opcode other than 7, and also for opcode 7 with function codes 7 to 15.
- R11: After adding 0x100 and 0x200, all three flags are clear, so a following jump-if-equal is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 4 | Decoded instruction code |
| func | input | 4 | Function code: arithmetic operation or jump condition |
| val_a | input | 32 | First register operand |
| val_b | input | 32 | Second register operand |
| val_c | input | 32 | Constant word from the instruction |
| result | output | 32 | Computed value, address or stack pointer |
| branch_taken | output | 1 | Jump condition holds for the current jump |

## Verification
The flags can only be seen through branch decisions. A flag that was computed or latched wrongly only shows up when a later conditional jump, checked in the cycle after the arithmetic edge, resolves the wrong way. A wrong flag can also survive silently across non-arithmetic instructions, such as a push that follows. For this reason, each flag state is probed with the full set of jump conditions right after it is written. The same probes are repeated after a non-arithmetic instruction to expose loads that should not have happened. Operand selection errors appear at once on the result port in the same cycle.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [3:0] {
    OPC_IDLE   = 4'h0,
    OPC_STOP   = 4'h1,
    OPC_MOVRR  = 4'h2,
    OPC_MOVIR  = 4'h3,
    OPC_STORE  = 4'h4,
    OPC_LOAD   = 4'h5,
    OPC_ARITH  = 4'h6,
    OPC_JUMP   = 4'h7,
    OPC_CALL   = 4'h8,
    OPC_RETURN = 4'h9,
    OPC_PUSH   = 4'hA,
    OPC_POP    = 4'hB
  } opcode_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  localparam logic [3:0] COND_ALWAYS = 4'd0;
  localparam logic [3:0] COND_LE     = 4'd1;
  localparam logic [3:0] COND_LT     = 4'd2;
  localparam logic [3:0] COND_EQ     = 4'd3;
  localparam logic [3:0] COND_NE     = 4'd4;
  localparam logic [3:0] COND_GE     = 4'd5;
  localparam logic [3:0] COND_GT     = 4'd6;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exec_operand_sel.sv
module exec_operand_sel
  import exec_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int STACK_STEP = 4
) (
  input  logic [3:0]        opcode,
  input  logic [3:0]        func,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] val_c,
  output logic [WORD_W-1:0] op_a,
  output logic [WORD_W-1:0] op_b,
  output alu_fn_e           fn,
  output logic              flag_load
);

  localparam logic [WORD_W-1:0] STEP_UP   = WORD_W'(STACK_STEP);
  localparam logic [WORD_W-1:0] STEP_DOWN = -STEP_UP;

  always_comb begin
    op_a = '0;
    op_b = '0;
    unique case (opcode)
      OPC_MOVRR:             begin op_a = val_a;     op_b = '0;    end
      OPC_ARITH:             begin op_a = val_a;     op_b = val_b; end
      OPC_MOVIR:             begin op_a = val_c;     op_b = '0;    end
      OPC_STORE, OPC_LOAD:   begin op_a = val_c;     op_b = val_b; end
      OPC_CALL, OPC_PUSH:    begin op_a = STEP_DOWN; op_b = val_b; end
      OPC_RETURN, OPC_POP:   begin op_a = STEP_UP;   op_b = val_b; end
      default:               begin op_a = '0;        op_b = '0;    end
    endcase
  end

  always_comb begin
    flag_load = (opcode == OPC_ARITH);
    if (flag_load && (func[3:2] == 2'b00)) fn = alu_fn_e'(func[1:0]);
    else                                   fn = FN_ADD;
  end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  alu_fn_e           fn,
  output logic [WORD_W-1:0] result,
  output flags_t            flags
);

  localparam int MSB = WORD_W - 1;

  always_comb begin
    unique case (fn)
      FN_ADD:  result = op_b + op_a;
      FN_SUB:  result = op_b - op_a;
      FN_AND:  result = op_b & op_a;
      default: result = op_b ^ op_a;
    endcase
  end

  always_comb begin
    flags.zf = (result == '0);
    flags.sf = result[MSB];
    unique case (fn)
      FN_ADD:  flags.of = (op_a[MSB] == op_b[MSB]) && (result[MSB] != op_b[MSB]);
      FN_SUB:  flags.of = (op_a[MSB] != op_b[MSB]) && (result[MSB] != op_b[MSB]);
      default: flags.of = 1'b0;
    endcase
  end

endmodule

// File: rtl/exec_cond_eval.sv
module exec_cond_eval
  import exec_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic [3:0] func,
  input  flags_t     cc,
  output logic       taken
);

  logic less;
  logic less_eq;
  logic cond_hit;

  always_comb begin
    less    = cc.sf ^ cc.of;
    less_eq = less | cc.zf;
    unique case (func)
      COND_ALWAYS: cond_hit = 1'b1;
      COND_LE:     cond_hit = less_eq;
      COND_LT:     cond_hit = less;
      COND_EQ:     cond_hit = cc.zf;
      COND_NE:     cond_hit = ~cc.zf;
      COND_GE:     cond_hit = ~less;
      COND_GT:     cond_hit = ~less_eq;
      default:     cond_hit = 1'b0;
    endcase
    taken = (opcode == OPC_JUMP) && cond_hit;
  end

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int STACK_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        opcode,
  input  logic [3:0]        func,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] val_c,
  output logic [WORD_W-1:0] result,
  output logic              branch_taken
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [WORD_W-1:0] op_a;
  logic [WORD_W-1:0] op_b;
  alu_fn_e           fn;
  logic              flag_load;
  flags_t            alu_flags;
  flags_t            cc_q;
  flags_t            cc_d;

  // reset: asserted at once, removed on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  exec_operand_sel #(.WORD_W(WORD_W), .STACK_STEP(STACK_STEP)) u_sel (
    .opcode    (opcode),
    .func      (func),
    .val_a     (val_a),
    .val_b     (val_b),
    .val_c     (val_c),
    .op_a      (op_a),
    .op_b      (op_b),
    .fn        (fn),
    .flag_load (flag_load)
  );

  exec_alu #(.WORD_W(WORD_W)) u_alu (
    .op_a   (op_a),
    .op_b   (op_b),
    .fn     (fn),
    .result (result),
    .flags  (alu_flags)
  );

  // flag register: next-state and storage kept apart
  always_comb begin
    cc_d = cc_q;
    if (flag_load) cc_d = alu_flags;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cc_q <= FLAGS_RESET;
    else             cc_q <= cc_d;
  end

  exec_cond_eval u_cond (
    .opcode (opcode),
    .func   (func),
    .cc     (cc_q),
    .taken  (branch_taken)
  );

  // R6: flags move only on arithmetic instructions
  p_cc_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode != OPC_ARITH) |=> $stable(cc_q));

  // R6: an arithmetic instruction leaves the ALU flags in the register
  p_cc_load_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode == OPC_ARITH) |=> (cc_q == $past(alu_flags)));

  // R7: logic operations never report overflow
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode == OPC_ARITH && (func == 4'd2 || func == 4'd3)) |-> !alu_flags.of);

  // R10: no branch outside the jump opcode
  p_branch_gate_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    branch_taken |-> (opcode == OPC_JUMP));

  // R9: unconditional and equal conditions follow the stored flags
  p_uncond_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode == OPC_JUMP && func == 4'd0) |-> branch_taken);

  p_equal_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode == OPC_JUMP && func == 4'd3) |-> (branch_taken == cc_q.zf));

  // R4: stack adjustments move by exactly the step
  p_stack_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode == OPC_POP || opcode == OPC_RETURN) |-> (result - val_b == WORD_W'(STACK_STEP)));

endmodule

// File: tb/tb_exec_unit.sv
module tb_exec_unit;

  localparam int W  = 32;
  localparam int NV = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   opcode;
  logic [3:0]   func;
  logic [W-1:0] val_a, val_b, val_c;
  logic [W-1:0] result;
  logic         branch_taken;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  exec_unit dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode       (opcode),
    .func         (func),
    .val_a        (val_a),
    .val_b        (val_b),
    .val_c        (val_c),
    .result       (result),
    .branch_taken (branch_taken)
  );

  // {req, opcode, func, val_a, val_b, val_c, expected result}
  localparam logic [139:0] VECS [NV] = '{
    {4'd1, 4'h6, 4'h0, 32'h0000_0005, 32'h0000_0007, 32'h0000_0063, 32'h0000_000C}, // R1 add
    {4'd1, 4'h6, 4'h1, 32'h0000_0003, 32'h0000_000A, 32'h0000_0000, 32'h0000_0007}, // R1 sub
    {4'd1, 4'h6, 4'h1, 32'h0000_000A, 32'h0000_0003, 32'h0000_0000, 32'hFFFF_FFF9}, // R1 sub negative
    {4'd1, 4'h6, 4'h2, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0000_0000, 32'hF000_F000}, // R1 and
    {4'd1, 4'h6, 4'h3, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0000_0000, 32'h0FF0_0FF0}, // R1 xor
    {4'd1, 4'h6, 4'h5, 32'h0000_0001, 32'h0000_0002, 32'h0000_0000, 32'h0000_0003}, // R1 undefined fn adds
    {4'd2, 4'h2, 4'h0, 32'hDEAD_BEEF, 32'h0000_1234, 32'h0000_0005, 32'hDEAD_BEEF}, // R2 copy
    {4'd2, 4'h3, 4'h0, 32'h0000_0001, 32'h0000_0002, 32'hCAFE_F00D, 32'hCAFE_F00D}, // R2 constant
    {4'd3, 4'h4, 4'h0, 32'h0000_0077, 32'h0000_1000, 32'h0000_0024, 32'h0000_1024}, // R3 store
    {4'd3, 4'h5, 4'h0, 32'h0000_0077, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0000_0010}, // R3 load
    {4'd4, 4'hA, 4'h0, 32'h0000_0055, 32'h0000_0100, 32'h0000_0009, 32'h0000_00FC}, // R4 push
    {4'd4, 4'h8, 4'h0, 32'h0000_0055, 32'h0000_0000, 32'h0000_0009, 32'hFFFF_FFFC}, // R4 call
    {4'd4, 4'hB, 4'h0, 32'h0000_0055, 32'h0000_00FC, 32'h0000_0009, 32'h0000_0100}, // R4 pop
    {4'd4, 4'h9, 4'h0, 32'h0000_0055, 32'hFFFF_FFFE, 32'h0000_0009, 32'h0000_0002}, // R4 return
    {4'd5, 4'h0, 4'h0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0000}, // R5 idle
    {4'd5, 4'h1, 4'h0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0000}, // R5 stop
    {4'd5, 4'h7, 4'h3, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0000}, // R5 jump
    {4'd5, 4'hE, 4'h0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0000}  // R5 unused
  };

  task automatic apply(input logic [3:0] o, input logic [3:0] f,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    @(negedge clk);
    opcode = o; func = f; val_a = a; val_b = b; val_c = c;
    #1;
  endtask

  task automatic chk_res(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s result actual=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic chk_br(input string req, input logic [3:0] f, input logic exp);
    apply(4'h7, f, '0, '0, '0);
    n_checks++;
    if (branch_taken !== exp) begin
      n_fail++;
      $display("FAIL %s jump fn %0d actual=%b expected=%b", req, f, branch_taken, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    opcode = 4'h0; func = 4'h0; val_a = '0; val_b = '0; val_c = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();

    // R8: reset flags zero=1 sign=0 overflow=0
    chk_br("R8", 4'd3, 1'b1);
    chk_br("R8", 4'd4, 1'b0);
    chk_br("R8", 4'd2, 1'b0);
    chk_br("R9 always", 4'd0, 1'b1);

    // R1..R5 result table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][135:132], VECS[i][131:128], VECS[i][127:96], VECS[i][95:64], VECS[i][63:32]);
      chk_res($sformatf("R%0d vector %0d", VECS[i][139:136], i), VECS[i][31:0]);
    end

    // R11: 0x100 + 0x200 clears all flags
    do_reset();
    apply(4'h6, 4'h0, 32'h200, 32'h100, '0);
    chk_res("R11", 32'h300);
    chk_br("R11 equal", 4'd3, 1'b0);
    chk_br("R9 ne", 4'd4, 1'b1);
    chk_br("R9 le", 4'd1, 1'b0);
    chk_br("R9 lt", 4'd2, 1'b0);
    chk_br("R9 ge", 4'd5, 1'b1);
    chk_br("R9 gt", 4'd6, 1'b1);

    // negative result without overflow: 1 - 2
    apply(4'h6, 4'h1, 32'h2, 32'h1, '0);
    chk_br("R9 lt neg", 4'd2, 1'b1);
    chk_br("R9 le neg", 4'd1, 1'b1);
    chk_br("R9 ge neg", 4'd5, 1'b0);
    chk_br("R9 gt neg", 4'd6, 1'b0);

    // R7: add overflow 0x7fffffff + 1 gives sign=1 overflow=1
    apply(4'h6, 4'h0, 32'h1, 32'h7FFF_FFFF, '0);
    chk_res("R7 add ovf", 32'h8000_0000);
    chk_br("R7 add ovf lt", 4'd2, 1'b0);
    chk_br("R7 add ovf gt", 4'd6, 1'b1);

    // R7: subtract overflow 0x80000000 - 1 gives sign=0 overflow=1
    apply(4'h6, 4'h1, 32'h1, 32'h8000_0000, '0);
    chk_res("R7 sub ovf", 32'h7FFF_FFFF);
    chk_br("R7 sub ovf lt", 4'd2, 1'b1);
    chk_br("R7 sub ovf ge", 4'd5, 1'b0);

    // R7: same-sign subtract does not overflow: 0x7fffffff - 0x7fffffff
    apply(4'h6, 4'h1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, '0);
    chk_br("R7 sub no ovf", 4'd3, 1'b1);

    // R7: AND with negative result clears overflow, less follows sign
    apply(4'h6, 4'h0, 32'h1, 32'h7FFF_FFFF, '0);
    apply(4'h6, 4'h2, 32'hFFFF_FFFF, 32'h8000_0000, '0);
    chk_br("R7 and lt", 4'd2, 1'b1);
    chk_br("R7 and ge", 4'd5, 1'b0);

    // R6: xor to zero, then non-arithmetic ops must not touch flags
    apply(4'h6, 4'h3, 32'h1234, 32'h1234, '0);
    apply(4'hA, 4'h0, 32'h0, 32'h0000_0004, 32'h0);
    chk_res("R6 push result", 32'h0);
    apply(4'h2, 4'h0, 32'h8000_0000, 32'h1, 32'h0);
    apply(4'h5, 4'h0, 32'h0, 32'hFFFF_FFFF, 32'h5);
    chk_br("R6 flags held eq", 4'd3, 1'b1);
    chk_br("R6 flags held lt", 4'd2, 1'b0);

    // R10: undefined jump codes and non-jump opcodes never branch
    chk_br("R10 fn7", 4'd7, 1'b0);
    chk_br("R10 fnF", 4'd15, 1'b0);
    apply(4'h6, 4'h0, 32'h0, 32'h0, '0);
    apply(4'h8, 4'h0, 32'h0, 32'h0, '0);
    n_checks++;
    if (branch_taken !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 non-jump actual=%b expected=0", branch_taken);
    end

    summary();
  end

endmodule